// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between a 12-bit narrow port A and a 24-bit wide port B. Port B is split into two 12-bit halves: half 1B is `b_o[11:0]` / `b_i[11:0]` and half 2B is `b_o[23:12]` / `b_i[23:12]`. In the A-to-B direction, the half-1B path has two register stages and the half-2B path has one. Two narrow words sent on successive clocks therefore leave the block together as one wide word.

In the B-to-A direction, each half of B has its own capture register. A half-select, registered on the clock, picks which of the two registers drives A. Every capture register has its own active-low enable.

The output enables for both ports are active low and pass through a register, so a change of direction only takes effect at a clock edge. The tri-state pads are modelled as a data output plus an active-high drive flag for each port.

Top module: `nw_bus_xchg`

## Requirements
- R1: While `rst_ni` is low, all data registers read zero, so `a_o` and `b_o` are 0, and both `a_oe_o` and `b_oe_o` are 0 (outputs not driven). This holds even if the enables are low and the clock runs.
- R2: The first half-1B stage takes `a_i` at a rising edge only when `cap1_ni` is 0. Otherwise it keeps its value.
- R3: At a rising edge with `cap2_ni` at 0, `b_o[23:12]` takes `a_i` and `b_o[11:0]` takes the first-stage value. With `cap2_ni` at 1, `b_o` holds.
- R4: Word N is sent with `cap1_ni`=0 at edge k, and word N+1 is sent with `cap2_ni`=0 at edge k+1. After edge k+1, `b_o` equals {N+1, N}, with N in half 1B.
- R5: `capa1_ni`=0 at an edge captures `b_i[11:0]` into the 1B readback register. `capa2_ni`=0 captures `b_i[23:12]` into the 2B readback register. Each register holds when its enable is 1.
- R6: `sel_i` is sampled at every rising edge. After the edge, `a_o` shows the 1B readback register if the sample was 0, or the 2B readback register if it was 1.
- R7: After each edge, `a_oe_o` and `b_oe_o` equal the inverse of `a_oe_ni` and `b_oe_ni` sampled at that edge. A change of these inputs between edges does not alter the outputs.
- R8: The data outputs always carry their registered data, whatever the enables are. Both ports may be driven at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 12 | Narrow port input data |
| b_i | input | 24 | Wide port input data, {2B, 1B} |
| cap1_ni | input | 1 | Enable for the first half-1B stage, active low |
| cap2_ni | input | 1 | Enable for the half-2B stage and the second half-1B stage, active low |
| capa1_ni | input | 1 | Enable for the 1B readback register, active low |
| capa2_ni | input | 1 | Enable for the 2B readback register, active low |
| sel_i | input | 1 | Readback half-select, registered (0 = 1B, 1 = 2B) |
| a_oe_ni | input | 1 | Port A output enable, active low, registered |
| b_oe_ni | input | 1 | Port B output enable, active low, registered |
| a_o | output | 12 | Narrow port output data |
| a_oe_o | output | 1 | Port A drive flag, high when driven |
| b_o | output | 24 | Wide port output data, {2B, 1B} |
| b_oe_o | output | 1 | Port B drive flag, high when driven |

## Verification
The pairing of words is swept over many arithmetically generated word pairs. Each pair is distinct in both halves, so a swap of halves or a missing pipeline stage shows up as a wrong field.

All four combinations of the two A-to-B enables are applied after a known preload, which separates a stage that captures from one that holds. All eight combinations of the two readback enables and the select are applied with fresh data, and the select is then flipped alone, which exposes a mux that is not registered.

The output enables are changed mid-cycle and sampled both before and after the next edge, which shows the one-cycle latency.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  parameter int NARROW_W = 12;
  localparam int HALVES = 2;

  typedef struct packed {
    logic a;
    logic b;
  } oe_pair_t;
endpackage

// File: rtl/xchg_en_reg.sv
module xchg_en_reg #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (!en_ni) q_o <= d_i;
  end

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |=> $stable(q_o));
endmodule

// File: rtl/xchg_a2b.sv
module xchg_a2b #(
  parameter int NW = xchg_pkg::NARROW_W,
  localparam int WW = 2 * NW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] a_i,
  input  logic          cap1_ni,
  input  logic          cap2_ni,
  output logic [WW-1:0] b_o
);
  logic [NW-1:0] st1_q, st2_q, hi_q;

  xchg_en_reg #(.W(NW)) u_st1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_ni(cap1_ni), .d_i(a_i), .q_o(st1_q));
  // second 1B stage shares the 2B enable so both halves move together
  xchg_en_reg #(.W(NW)) u_st2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_ni(cap2_ni), .d_i(st1_q), .q_o(st2_q));
  xchg_en_reg #(.W(NW)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_ni(cap2_ni), .d_i(a_i), .q_o(hi_q));

  assign b_o = {hi_q, st2_q};

  // R3
  hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap2_ni |=> b_o[WW-1:NW] == $past(a_i));
  // R3
  b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap2_ni |=> $stable(b_o));
  // R4
  pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap1_ni ##1 !cap2_ni) |=> b_o[NW-1:0] == $past(a_i, 2));
endmodule

// File: rtl/xchg_b2a.sv
module xchg_b2a #(
  parameter int NW = xchg_pkg::NARROW_W,
  localparam int WW = 2 * NW,
  localparam int H  = xchg_pkg::HALVES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [WW-1:0] b_i,
  input  logic [H-1:0]  cap_ni,
  input  logic          sel_i,
  output logic [NW-1:0] a_o
);
  logic [NW-1:0] half_q [H];
  logic          sel_q;

  for (genvar g = 0; g < H; g++) begin : g_half
    xchg_en_reg #(.W(NW)) u_rb (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_ni(cap_ni[g]),
      .d_i(b_i[g*NW +: NW]), .q_o(half_q[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel_i;
  end

  assign a_o = sel_q ? half_q[1] : half_q[0];

  // R6
  sel_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !cap_ni[1]) |=> a_o == $past(b_i[WW-1:NW]));
  // R6
  sel_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !cap_ni[0]) |=> a_o == $past(b_i[NW-1:0]));
endmodule

// File: rtl/xchg_oe_ctl.sv
module xchg_oe_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_oe_ni,
  input  logic b_oe_ni,
  output logic a_oe_o,
  output logic b_oe_o
);
  import xchg_pkg::*;
  oe_pair_t oe_nq;

  // reset parks both ports in the undriven state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_nq <= '{a: 1'b1, b: 1'b1};
    else         oe_nq <= '{a: a_oe_ni, b: b_oe_ni};
  end

  assign a_oe_o = ~oe_nq.a;
  assign b_oe_o = ~oe_nq.b;

  // R7
  a_oe_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_oe_ni |=> !a_oe_o);
  // R7
  b_oe_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_oe_ni |=> b_oe_o);
endmodule

// File: rtl/nw_bus_xchg.sv
module nw_bus_xchg #(
  parameter int NW = xchg_pkg::NARROW_W,
  localparam int WW = 2 * NW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] a_i,
  input  logic [WW-1:0] b_i,
  input  logic          cap1_ni,
  input  logic          cap2_ni,
  input  logic          capa1_ni,
  input  logic          capa2_ni,
  input  logic          sel_i,
  input  logic          a_oe_ni,
  input  logic          b_oe_ni,
  output logic [NW-1:0] a_o,
  output logic          a_oe_o,
  output logic [WW-1:0] b_o,
  output logic          b_oe_o
);
  xchg_a2b #(.NW(NW)) u_a2b (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i),
    .cap1_ni(cap1_ni), .cap2_ni(cap2_ni), .b_o(b_o));

  xchg_b2a #(.NW(NW)) u_b2a (
    .clk_i(clk_i), .rst_ni(rst_ni), .b_i(b_i),
    .cap_ni({capa2_ni, capa1_ni}), .sel_i(sel_i), .a_o(a_o));

  xchg_oe_ctl u_oe (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_oe_ni(a_oe_ni), .b_oe_ni(b_oe_ni),
    .a_oe_o(a_oe_o), .b_oe_o(b_oe_o));

  // R8
  both_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_oe_ni && !b_oe_ni) |=> (a_oe_o && b_oe_o));
endmodule

// File: tb/sim_nw_bus_xchg.sv
module sim_nw_bus_xchg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] a_i = '0;
  logic [23:0] b_i = '0;
  logic        cap1_ni = 1'b1, cap2_ni = 1'b1, capa1_ni = 1'b1, capa2_ni = 1'b1;
  logic        sel_i = 1'b0, a_oe_ni = 1'b1, b_oe_ni = 1'b1;
  logic [11:0] a_o;
  logic [23:0] b_o;
  logic        a_oe_o, b_oe_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [23:0] exp_b;
  logic [11:0] exp_a;

  always #10 clk_i = ~clk_i;

  nw_bus_xchg u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
    .cap1_ni(cap1_ni), .cap2_ni(cap2_ni), .capa1_ni(capa1_ni), .capa2_ni(capa2_ni),
    .sel_i(sel_i), .a_oe_ni(a_oe_ni), .b_oe_ni(b_oe_ni),
    .a_o(a_o), .a_oe_o(a_oe_o), .b_o(b_o), .b_oe_o(b_oe_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state, enables low and clock running
    cap1_ni = 0; cap2_ni = 0; capa1_ni = 0; capa2_ni = 0;
    a_oe_ni = 0; b_oe_ni = 0; a_i = 12'habc; b_i = 24'h123456;
    step(); step();
    chk("R1 b_o", b_o, 0);
    chk("R1 a_o", a_o, 0);
    chk("R1 a_oe_o", a_oe_o, 0);
    chk("R1 b_oe_o", b_oe_o, 0);
    cap1_ni = 1; cap2_ni = 1; capa1_ni = 1; capa2_ni = 1;
    a_oe_ni = 1; b_oe_ni = 1;
    rst_ni = 1;
    step();
    exp_b = '0;

    // R4: word pairs
    for (int i = 0; i < 48; i++) begin
      logic [11:0] w0, w1;
      w0 = 12'((i * 293 + 17) & 12'hfff);
      w1 = 12'((i * 611 + 3) & 12'hfff);
      a_i = w0; cap1_ni = 0; cap2_ni = 1;
      step();
      chk("R3 hold during first word", b_o, exp_b);
      a_i = w1; cap1_ni = 1; cap2_ni = 0;
      step();
      cap2_ni = 1;
      exp_b = {w1, w0};
      chk("R4 pair", b_o, exp_b);
    end

    // R2 / R3: every enable combination
    for (int c = 0; c < 4; c++) begin
      logic [11:0] x1, x2, x3, st1;
      x1 = 12'(12'h111 * (c + 1));
      x2 = 12'(12'h0a5 + c * 12'h202);
      x3 = 12'(12'hf0f - c);
      a_i = x1; cap1_ni = 0; cap2_ni = 1;
      step();
      a_i = x2; cap1_ni = c[0]; cap2_ni = c[1];
      step();
      if (!c[1]) exp_b = {x2, x1};
      chk("R3 combo", b_o, exp_b);
      st1 = c[0] ? x1 : x2;
      a_i = x3; cap1_ni = 1; cap2_ni = 0;
      step();
      cap2_ni = 1;
      exp_b = {x3, st1};
      chk("R2 first stage", b_o[11:0], st1);
      chk("R3 flush high", b_o[23:12], x3);
    end

    // R5 / R6: readback registers and select
    for (int j = 0; j < 4; j++) begin
      for (int k = 0; k < 8; k++) begin
        logic [11:0] p1, p2, q1, q2, r1, r2;
        p1 = 12'(12'h101 * (j + 1) + k);
        p2 = 12'(12'h7e0 - j * 12'h31 - k);
        q1 = 12'(p1 ^ 12'hc3c);
        q2 = 12'(p2 ^ 12'h5a5);
        b_i = {p2, p1}; capa1_ni = 0; capa2_ni = 0; sel_i = 0;
        step();
        b_i = {q2, q1}; capa1_ni = k[0]; capa2_ni = k[1]; sel_i = k[2];
        step();
        r1 = k[0] ? p1 : q1;
        r2 = k[1] ? p2 : q2;
        exp_a = k[2] ? r2 : r1;
        chk("R5 capture", a_o, exp_a);
        capa1_ni = 1; capa2_ni = 1; sel_i = ~k[2];
        b_i = 24'hffffff;
        #3 chk("R6 sel not yet taken", a_o, exp_a);
        step();
        exp_a = k[2] ? r1 : r2;
        chk("R6 sel flip", a_o, exp_a);
      end
    end

    // R7 / R8: registered output enables
    for (int k = 0; k < 4; k++) begin
      logic pa, pb;
      pa = a_oe_o; pb = b_oe_o;
      a_oe_ni = k[0]; b_oe_ni = k[1];
      #3;
      chk("R7 a_oe before edge", a_oe_o, pa);
      chk("R7 b_oe before edge", b_oe_o, pb);
      step();
      chk("R7 a_oe after edge", a_oe_o, !k[0]);
      chk("R7 b_oe after edge", b_oe_o, !k[1]);
      chk("R8 b data", b_o, exp_b);
      chk("R8 a data", a_o, exp_a);
    end

    finish_run();
  end
endmodule